// File: doc/BRIEF.md
# Interrupt and Sync Status Register Block for an Instruction-Driven SPI Controller

This block is the register-side interrupt logic of an SPI controller that runs a stream of queued instructions. It watches the occupancy of the three FIFOs around the controller: free room in the command FIFO, free room in the transmit FIFO and fill level of the receive FIFO. It turns each count into a level-driven interrupt source by comparing it against a fixed threshold. Two more sources are sticky. One records that a sync instruction completed and the other that an offload sync completed. Each of these latches the 8-bit ID that came with the event.

Software sees everything through a simple register port. Writes take one cycle. Reads are combinational from the address. The port gives access to an enable mask, a pending view, a masked source view, the two latched IDs, the three FIFO counts and an engine reset control. A single interrupt line, registered, is high whenever an enabled source is pending.

The engine reset control is a two-state machine. ST_RUN is entered from reset and releases the engine. ST_HOLD holds the engine in reset. A write of 1 to bit 0 of the reset register takes ST_RUN to ST_HOLD. A write of 0 to bit 0 takes ST_HOLD back to ST_RUN. Any other cycle keeps the current state.

Top module: `spie_irq_regs`

## Requirements
- R1: After reset the enable mask, both sticky sync bits, both IDs, the interrupt output and the engine reset output are all 0.
- R2: The interrupt source bits are pending bit 0 (command FIFO room >= CMD_AE_ROOM), pending bit 1 (transmit FIFO room >= TX_AE_ROOM) and pending bit 2 (receive FIFO level >= RX_AF_LVL). These three bits follow the current counts and are not sticky. The defaults for all three thresholds are 12.
- R3: A pulse on sync_stb sets pending bit 3, and a pulse on off_sync_stb sets pending bit 4. Each of these bits stays set until it is cleared.
- R4: Each sync event latches its 8-bit ID. The sync ID reads back at 0xC0 and the offload sync ID at 0xC4, both zero-extended. Each ID keeps its value until its next event.
- R5: Writing 1 to bit 3 or bit 4 of the pending register at 0x84 clears that bit. Writing 0 has no effect, and writes to bits 2:0 have no effect. If an event and its clear arrive in the same cycle, the bit ends set.
- R6: The enable register at 0x80 is read/write in bits 4:0, and its bits 31:5 read as 0.
- R7: Reading 0x88 returns pending AND enable in bits 4:0. Reading 0x84 returns the pending bits in bits 4:0.
- R8: irq_o is high in the cycle after any bit of pending AND enable is high, and low otherwise.
- R9: The reset register is at 0x40. Writing 1 to bit 0 raises eng_rst_o from the next cycle on, and writing 0 to bit 0 lowers it. Bit 0 of a read of 0x40 returns the current hold state.
- R10: 0xD0, 0xD4 and 0xD8 read back the command room, transmit room and receive level, zero-extended. Every other address reads 0. Writes to read-only or unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for reg_addr and reg_wdata |
| reg_addr | input | ADDR_W | Byte address for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| cmd_room | input | CNT_W | Free entries in the command FIFO |
| tx_room | input | CNT_W | Free entries in the transmit FIFO |
| rx_level | input | CNT_W | Filled entries in the receive FIFO |
| sync_stb | input | 1 | One-cycle sync completion event |
| sync_id | input | 8 | ID that goes with sync_stb |
| off_sync_stb | input | 1 | One-cycle offload sync completion event |
| off_sync_id | input | 8 | ID that goes with off_sync_stb |
| irq_o | output | 1 | Interrupt request |
| eng_rst_o | output | 1 | Engine held in reset while high |

## Verification
The assertions assume the following about the inputs:
- Each event strobe lasts one cycle, and its ID is valid in that same cycle.
- The register port never reads and writes in the same cycle.

The stimulus respects these assumptions. It drives every strobe and write for exactly one clock, from the falling edge, and it reads only between writes. The random FIFO counts cover values on both sides of each threshold, so every level source toggles. Some cycles put an event and a write-one-to-clear together on purpose, to reach the set-wins case.

// File: rtl/spie_irq_pkg.sv
package spie_irq_pkg;
    localparam int NSRC = 5;

    localparam int SRC_CMD_AE = 0;
    localparam int SRC_TX_AE  = 1;
    localparam int SRC_RX_AF  = 2;
    localparam int SRC_SYNC   = 3;
    localparam int SRC_OSYNC  = 4;

    localparam logic [11:0] OFF_RESET   = 12'h040;
    localparam logic [11:0] OFF_ENABLE  = 12'h080;
    localparam logic [11:0] OFF_PENDING = 12'h084;
    localparam logic [11:0] OFF_SOURCE  = 12'h088;
    localparam logic [11:0] OFF_SYNC_ID = 12'h0C0;
    localparam logic [11:0] OFF_OSYNCID = 12'h0C4;
    localparam logic [11:0] OFF_CMDROOM = 12'h0D0;
    localparam logic [11:0] OFF_TXROOM  = 12'h0D4;
    localparam logic [11:0] OFF_RXLEVEL = 12'h0D8;

    typedef enum logic {ST_RUN = 1'b0, ST_HOLD = 1'b1} eng_state_t;
endpackage

// File: rtl/spie_sync_event.sv
module spie_sync_event #(
    parameter int ID_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            evt_i,
    input  logic [ID_W-1:0] id_i,
    input  logic            clr_i,
    output logic            pend_o,
    output logic [ID_W-1:0] id_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
            id_o   <= '0;
        end else if (evt_i) begin
            pend_o <= 1'b1;
            id_o   <= id_i;
        end else if (clr_i) begin
            pend_o <= 1'b0;
        end
    end

    p_event_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> pend_o);
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> pend_o);
    p_id_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> (id_o == $past(id_i)));
    p_id_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_i |=> $stable(id_o));
    p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !evt_i) |=> !pend_o);
endmodule

// File: rtl/spie_level_src.sv
module spie_level_src #(
    parameter int CNT_W = 8,
    parameter int THR   = 12
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic             hit_o
);
    localparam logic [CNT_W-1:0] THR_V = CNT_W'(THR);

    always_comb hit_o = (cnt_i >= THR_V);
endmodule

// File: rtl/spie_eng_ctl.sv
module spie_eng_ctl
    import spie_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic bit_i,
    output logic hold_o
);
    eng_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (wr_i && bit_i)  state_d = ST_HOLD;
            ST_HOLD: if (wr_i && !bit_i) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_comb hold_o = (state_q == ST_HOLD);

    p_enter_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && bit_i) |=> hold_o);
    p_leave_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !bit_i) |=> !hold_o);
    p_hold_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(hold_o));
endmodule

// File: rtl/spie_irq_regs.sv
module spie_irq_regs
    import spie_irq_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int CNT_W       = 8,
    parameter int CMD_AE_ROOM = 12,
    parameter int TX_AE_ROOM  = 12,
    parameter int RX_AF_LVL   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [CNT_W-1:0]  cmd_room,
    input  logic [CNT_W-1:0]  tx_room,
    input  logic [CNT_W-1:0]  rx_level,
    input  logic              sync_stb,
    input  logic [7:0]        sync_id,
    input  logic              off_sync_stb,
    input  logic [7:0]        off_sync_id,
    output logic              irq_o,
    output logic              eng_rst_o
);
    localparam int NLVL = 3;
    localparam int ID_W = 8;

    logic [NLVL-1:0][CNT_W-1:0] cnt_w;
    logic [NSRC-1:0]            pend_w;
    logic [NSRC-1:0]            src_w;
    logic [NSRC-1:0]            en_q;
    logic                       irq_q;
    logic [1:0]                 evt_w;
    logic [1:0][ID_W-1:0]       evid_w;
    logic [1:0][ID_W-1:0]       idq_w;
    logic [1:0]                 clr_w;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [11:0] off);
        return a == ADDR_W'(off);
    endfunction

    assign cnt_w = {rx_level, tx_room, cmd_room};

    // level-driven sources, one comparator per FIFO
    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        localparam int THR = (g == SRC_CMD_AE) ? CMD_AE_ROOM :
                             (g == SRC_TX_AE)  ? TX_AE_ROOM  : RX_AF_LVL;
        spie_level_src #(.CNT_W(CNT_W), .THR(THR)) u_lvl (
            .cnt_i (cnt_w[g]),
            .hit_o (pend_w[g])
        );
    end

    // sticky sync sources with latched IDs
    assign evt_w  = {off_sync_stb, sync_stb};
    assign evid_w = {off_sync_id, sync_id};
    for (genvar s = 0; s < 2; s++) begin : g_sync
        assign clr_w[s] = reg_wr && hit(reg_addr, OFF_PENDING) && reg_wdata[SRC_SYNC + s];
        spie_sync_event #(.ID_W(ID_W)) u_evt (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt_i  (evt_w[s]),
            .id_i   (evid_w[s]),
            .clr_i  (clr_w[s]),
            .pend_o (pend_w[SRC_SYNC + s]),
            .id_o   (idq_w[s])
        );
    end

    spie_eng_ctl u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (reg_wr && hit(reg_addr, OFF_RESET)),
        .bit_i  (reg_wdata[0]),
        .hold_o (eng_rst_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            irq_q <= 1'b0;
        end else begin
            if (reg_wr && hit(reg_addr, OFF_ENABLE)) en_q <= reg_wdata[NSRC-1:0];
            irq_q <= |src_w;
        end
    end

    assign src_w = pend_w & en_q;
    assign irq_o = irq_q;

    always_comb begin
        reg_rdata = '0;
        if (hit(reg_addr, OFF_RESET))        reg_rdata[0]        = eng_rst_o;
        else if (hit(reg_addr, OFF_ENABLE))  reg_rdata[NSRC-1:0] = en_q;
        else if (hit(reg_addr, OFF_PENDING)) reg_rdata[NSRC-1:0] = pend_w;
        else if (hit(reg_addr, OFF_SOURCE))  reg_rdata[NSRC-1:0] = src_w;
        else if (hit(reg_addr, OFF_SYNC_ID)) reg_rdata[ID_W-1:0] = idq_w[0];
        else if (hit(reg_addr, OFF_OSYNCID)) reg_rdata[ID_W-1:0] = idq_w[1];
        else if (hit(reg_addr, OFF_CMDROOM)) reg_rdata[CNT_W-1:0] = cmd_room;
        else if (hit(reg_addr, OFF_TXROOM))  reg_rdata[CNT_W-1:0] = tx_room;
        else if (hit(reg_addr, OFF_RXLEVEL)) reg_rdata[CNT_W-1:0] = rx_level;
    end

    p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |=> !irq_o);
    p_irq_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_stb && en_q[SRC_SYNC] && !(reg_wr && hit(reg_addr, OFF_ENABLE))) |=> ##1 irq_o);
    p_enable_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && hit(reg_addr, OFF_ENABLE)) |=> $stable(en_q));
endmodule

// File: tb/tb_spie_irq_regs.sv
module tb_spie_irq_regs;
    localparam int CLK_PERIOD = 10;
    localparam int THR = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  cmd_room = '0, tx_room = '0, rx_level = '0;
    logic        sync_stb = 1'b0, off_sync_stb = 1'b0;
    logic [7:0]  sync_id = '0, off_sync_id = '0;
    logic        irq_o, eng_rst_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [4:0] m_en = '0;
    logic       m_sp = 1'b0, m_op = 1'b0, m_hold = 1'b0;
    logic [7:0] m_sid = '0, m_oid = '0;
    logic       m_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spie_irq_regs dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_room(cmd_room),
        .tx_room(tx_room), .rx_level(rx_level), .sync_stb(sync_stb),
        .sync_id(sync_id), .off_sync_stb(off_sync_stb), .off_sync_id(off_sync_id),
        .irq_o(irq_o), .eng_rst_o(eng_rst_o)
    );

    function automatic logic [4:0] exp_pend();
        return {m_op, m_sp, rx_level >= 8'(THR), tx_room >= 8'(THR), cmd_room >= 8'(THR)};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    // one clock edge; model advances with the values driven before it
    task automatic tick();
        @(posedge clk);
        m_irq = |(exp_pend() & m_en);
        if (reg_wr && reg_addr == 12'h080) m_en = reg_wdata[4:0];
        if (reg_wr && reg_addr == 12'h040) m_hold = reg_wdata[0];
        if (reg_wr && reg_addr == 12'h084) begin
            if (reg_wdata[3]) m_sp = 1'b0;
            if (reg_wdata[4]) m_op = 1'b0;
        end
        if (sync_stb)     begin m_sp = 1'b1; m_sid = sync_id;     end
        if (off_sync_stb) begin m_op = 1'b1; m_oid = off_sync_id; end
        @(negedge clk);
        reg_wr = 1'b0; sync_stb = 1'b0; off_sync_stb = 1'b0;
        chk("R8 irq", {31'b0, irq_o}, {31'b0, m_irq});
        chk("R9 eng_rst", {31'b0, eng_rst_o}, {31'b0, m_hold});
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    endtask

    task automatic check_all();
        rd("R6 enable",   12'h080, {27'b0, m_en});
        rd("R2/R3 pending", 12'h084, {27'b0, exp_pend()});
        rd("R7 source",   12'h088, {27'b0, exp_pend() & m_en});
        rd("R4 sync id",  12'h0C0, {24'b0, m_sid});
        rd("R4 osync id", 12'h0C4, {24'b0, m_oid});
        rd("R10 cmd room", 12'h0D0, {24'b0, cmd_room});
        rd("R10 tx room",  12'h0D4, {24'b0, tx_room});
        rd("R10 rx level", 12'h0D8, {24'b0, rx_level});
        rd("R9 reset reg", 12'h040, {31'b0, m_hold});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        chk("R1 eng_rst", {31'b0, eng_rst_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all();

        // R6 upper enable bits read 0
        wr(12'h080, 32'hFFFF_FFE0); tick();
        rd("R6 upper bits", 12'h080, 32'h0);

        // R2 thresholds exactly at and below the limits
        cmd_room = 8'd12; tx_room = 8'd11; rx_level = 8'd12;
        wr(12'h080, 32'h1F); tick(); tick();
        check_all();
        cmd_room = 8'd11; rx_level = 8'd11; tick(); tick();
        rd("R2 not sticky", 12'h084, 32'h0);

        // R5 clear of bits 2:0 ignored, set wins over clear
        cmd_room = 8'd20; wr(12'h084, 32'h07); tick();
        rd("R5 level bits kept", 12'h084, 32'h01);
        sync_stb = 1'b1; sync_id = 8'hA5; wr(12'h084, 32'h08); tick();
        rd("R5 set wins", 12'h084, 32'h09);
        wr(12'h084, 32'h08); tick();
        rd("R5 w1c", 12'h084, 32'h01);

        // R10 read-only and unmapped writes
        wr(12'h0C0, 32'hFF); tick();
        wr(12'h088, 32'hFF); tick();
        wr(12'h044, 32'hFF); tick();
        rd("R10 unmapped", 12'h044, 32'h0);
        rd("R10 addr zero", 12'h000, 32'h0);
        check_all();

        // R9 hold and release
        wr(12'h040, 32'h1); tick();
        wr(12'h040, 32'h1); tick();
        wr(12'h040, 32'h0); tick();
        check_all();

        // random mix
        for (int i = 0; i < 400; i++) begin
            cmd_room = 8'($urandom_range(0, 20));
            tx_room  = 8'($urandom_range(0, 20));
            rx_level = 8'($urandom_range(0, 20));
            case ($urandom_range(0, 6))
                0: wr(12'h080, $urandom());
                1: begin sync_stb = 1'b1; sync_id = 8'($urandom()); end
                2: begin off_sync_stb = 1'b1; off_sync_id = 8'($urandom()); end
                3: wr(12'h084, $urandom());
                4: wr(12'h040, {31'b0, 1'($urandom())});
                5: begin sync_stb = 1'b1; off_sync_stb = 1'b1;
                         sync_id = 8'($urandom()); off_sync_id = 8'($urandom());
                         wr(12'h084, 32'h18); end
                default: ;
            endcase
            tick();
            check_all();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule